// File: doc/BRIEF.md
# Two-Stage Warning Watchdog with NMI Merge

This block guards a processor against a hung program in two steps. Software arms it by writing a control word that carries an enable bit, an unlock key, a reload selector and a count. The watchdog then counts down once per strobe on a slow tick input. Each strobe arrives at roughly 760 Hz and comes from a prescaler outside the block. When the countdown first runs out, the watchdog does not reset the system. It raises a non-maskable interrupt (NMI) level and starts a short grace countdown. If no accepted control write arrives before the grace countdown also runs out, the block emits a one-cycle system reset request and returns to its idle state.

A small NMI merge stage sits next to the watchdog. It samples every level-sensitive NMI source into its own bit of a pending mask. The processor NMI line stays high while any bit in that mask is set. The watchdog drives source slot 1. External sources fill the remaining slots in index order.

The watchdog state machine has three states:
- `ST_OFF`: idle, not counting.
- `ST_RUN`: primary countdown.
- `ST_GRACE`: NMI raised, grace countdown running.

Its transitions are:
- **arm** (`ST_OFF` → `ST_RUN`): an accepted write with enable set.
- **kick** (`ST_RUN`/`ST_GRACE` → `ST_RUN`): an accepted write with enable set.
- **disarm** (any state → `ST_OFF`): an accepted write with enable clear.
- **warn** (`ST_RUN` → `ST_GRACE`): the last tick of the primary count.
- **bite** (`ST_GRACE` → `ST_OFF`): the last tick of the grace count. This transition also pulses the reset request.

Top module: `wdog_warn_top`

## Requirements
- R1: After reset the watchdog is in `ST_OFF`, and `wd_nmi`, `rst_req`, `nmi_pending` and `cpu_nmi` are all 0.
- R2: A write is accepted only when `wr_key` equals `KEY_VAL` (default 8'hA5). A write with any other key changes none of the outputs, either at once or on later ticks.
- R3: An accepted write with `wr_enable`=1 issued from `ST_OFF` loads the count field N into the down-counter. The value N=0 stands for 256. The primary expiry then happens on the Nth tick.
- R4: On the primary expiry `wd_nmi` goes high in the cycle after the tick and no reset is requested. The counter reloads with `GRACE` (default 10) ticks.
- R5: If the counter expires again while in `ST_GRACE`, `rst_req` is high for exactly one cycle. In that same cycle `wd_nmi` drops low and the block returns to `ST_OFF`.
- R6: Any accepted write drops `wd_nmi` in the following cycle and clears the expiry history. The next expiry is therefore again a warning and not a reset.
- R7: `wr_reload`=1 in an accepted enabling write reloads the counter from the count field. With `wr_reload`=0 in `ST_RUN` or `ST_GRACE`, the counter keeps its current value.
- R8: An accepted write with `wr_enable`=0 stops counting and clears `wd_nmi`. Ticks in `ST_OFF` have no effect.
- R9: The counter moves only on cycles where `tick`=1. If an accepted write and a tick fall in the same cycle, the write wins and the tick is discarded.
- R10: Each `nmi_pending` bit equals the level of its source one cycle earlier. The watchdog is bit 1 and `ext_nmi[0]` is bit 0. `cpu_nmi` is high exactly when some pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Control write strobe |
| wr_enable | input | 1 | Enable field of the control word |
| wr_key | input | KEY_W | Unlock key field |
| wr_reload | input | 1 | Reload selector: 1 = load count field |
| wr_count | input | CNT_W | Count field, 0 means 2**CNT_W |
| tick | input | 1 | Slow tick-enable strobe |
| ext_nmi | input | NSRC-1 | External level-sensitive NMI sources |
| wd_nmi | output | 1 | Watchdog warning level (high in `ST_GRACE`) |
| nmi_pending | output | NSRC | Sampled NMI pending mask |
| cpu_nmi | output | 1 | Merged processor NMI line |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted counter or state register shows up as a warning or a reset that comes early or late. With the default settings the error becomes visible within at most 256 ticks at `wd_nmi`, and within 10 more ticks at `rst_req`. A history bit that fails to clear turns a later warning directly into a reset. The bench sees this in the first cycle after the tick that should only have warned. A wrong pending bit appears on `nmi_pending` and `cpu_nmi` one cycle after the source changes. Every cycle is compared against a behavioural model, so a divergence is reported in the cycle where it first reaches a port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_GRACE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned KEY_W   = 8,
    parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
    parameter int unsigned GRACE   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             tick,
    output logic             wd_nmi,
    output logic             rst_req
);
    localparam int unsigned CTR_W = CNT_W + 1;
    localparam logic [CTR_W-1:0] FULL_CNT  = CTR_W'(1) << CNT_W;
    localparam logic [CTR_W-1:0] GRACE_CNT = CTR_W'(GRACE);

    wd_state_e        state_q, state_d;
    logic [CTR_W-1:0] cnt_q, cnt_d;
    logic             bite_d, rst_q;
    logic             write_ok;
    logic             last_tick;
    logic [CTR_W-1:0] load_val;

    assign write_ok  = wr_valid && (wr_key == KEY_VAL);
    assign last_tick = (cnt_q <= CTR_W'(1));
    assign load_val  = (wr_count == '0) ? FULL_CNT : {1'b0, wr_count};

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bite_d  = 1'b0;
        if (write_ok) begin
            if (!wr_enable) begin
                state_d = ST_OFF;                      // disarm
            end else begin
                state_d = ST_RUN;                      // arm or kick
                if (state_q == ST_OFF || wr_reload)
                    cnt_d = load_val;
            end
        end else begin
            unique case (state_q)
                ST_OFF: ;
                ST_RUN: if (tick) begin
                    if (last_tick) begin
                        state_d = ST_GRACE;            // warn
                        cnt_d   = GRACE_CNT;
                    end else begin
                        cnt_d = cnt_q - CTR_W'(1);
                    end
                end
                ST_GRACE: if (tick) begin
                    if (last_tick) begin
                        state_d = ST_OFF;              // bite
                        bite_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CTR_W'(1);
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= bite_d;
    end

    assign rst_req = rst_q;
    assign wd_nmi  = (state_q == ST_GRACE);
endmodule

// File: rtl/nmi_merge.sv
module nmi_merge #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] pend,
    output logic            cpu_nmi
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= src[i];
        end
    end

    assign cpu_nmi = |pend;
endmodule

// File: rtl/wdog_warn_top.sv
module wdog_warn_top #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned KEY_W   = 8,
    parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
    parameter int unsigned GRACE   = 10,
    parameter int unsigned NSRC    = 2,
    parameter int unsigned WD_SLOT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             tick,
    input  logic [NSRC-2:0]  ext_nmi,
    output logic             wd_nmi,
    output logic [NSRC-1:0]  nmi_pending,
    output logic             cpu_nmi,
    output logic             rst_req
);
    logic [NSRC-1:0] src;

    wdog_core #(
        .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL), .GRACE(GRACE)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_enable(wr_enable),
        .wr_key(wr_key), .wr_reload(wr_reload), .wr_count(wr_count),
        .tick(tick), .wd_nmi(wd_nmi), .rst_req(rst_req)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < WD_SLOT) begin : g_lo
            assign src[i] = ext_nmi[i];
        end else if (i == WD_SLOT) begin : g_wd
            assign src[i] = wd_nmi;
        end else begin : g_hi
            assign src[i] = ext_nmi[i-1];
        end
    end

    nmi_merge #(.NSRC(NSRC)) u_merge (
        .clk(clk), .rst_n(rst_n), .src(src), .pend(nmi_pending), .cpu_nmi(cpu_nmi)
    );
endmodule

// File: rtl/wdog_warn_checker.sv
module wdog_warn_checker #(
    parameter int unsigned KEY_W   = 8,
    parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
    parameter int unsigned NSRC    = 2,
    parameter int unsigned WD_SLOT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [KEY_W-1:0] wr_key,
    input logic             tick,
    input logic             wd_nmi,
    input logic [NSRC-1:0]  nmi_pending,
    input logic             cpu_nmi,
    input logic             rst_req
);
    AST_RST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                              // R5
    AST_RST_FOLLOWS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(wd_nmi) && !wd_nmi));                            // R5
    AST_WRITE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_key == KEY_VAL) |=> !wd_nmi);                       // R6
    AST_WARN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_nmi) |-> $past(tick));                                     // R4
    AST_RST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(tick));                                    // R9
    AST_WD_SLOT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pending[WD_SLOT] == $past(wd_nmi));                             // R10
    AST_WARN_REACHES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_nmi) |=> cpu_nmi);                                         // R10
endmodule

bind wdog_warn_top wdog_warn_checker #(
    .KEY_W(KEY_W), .KEY_VAL(KEY_VAL), .NSRC(NSRC), .WD_SLOT(WD_SLOT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_key(wr_key),
    .tick(tick), .wd_nmi(wd_nmi), .nmi_pending(nmi_pending),
    .cpu_nmi(cpu_nmi), .rst_req(rst_req)
);

// File: tb/wdog_warn_top_bench.sv
`timescale 1ns/1ps
module wdog_warn_top_bench;
    localparam int KEY   = 8'hA5;
    localparam int GRACE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_enable = 1'b0;
    logic [7:0] wr_key = '0;
    logic       wr_reload = 1'b0;
    logic [7:0] wr_count = '0;
    logic       tick = 1'b0;
    logic [0:0] ext_nmi = '0;
    logic       wd_nmi;
    logic [1:0] nmi_pending;
    logic       cpu_nmi;
    logic       rst_req;

    int checks = 0;
    int errors = 0;

    // behavioural model: 0 off, 1 run, 2 grace
    int   m_state = 0;
    int   m_cnt   = 0;
    bit   m_rst   = 0;
    bit [1:0] m_pend = '0;

    always #4 clk = ~clk;

    wdog_warn_top u_wdog_warn_top (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_enable(wr_enable),
        .wr_key(wr_key), .wr_reload(wr_reload), .wr_count(wr_count),
        .tick(tick), .ext_nmi(ext_nmi), .wd_nmi(wd_nmi),
        .nmi_pending(nmi_pending), .cpu_nmi(cpu_nmi), .rst_req(rst_req)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "wd_nmi", int'(wd_nmi), (m_state == 2) ? 1 : 0);
        check(tag, "rst_req", int'(rst_req), int'(m_rst));
        check(tag, "nmi_pending", int'(nmi_pending), int'(m_pend));
        check(tag, "cpu_nmi", int'(cpu_nmi), (m_pend != 0) ? 1 : 0);
    endtask

    task automatic step(bit wv, bit en, int key, bit rl, int cnt, bit tk, bit ext,
                        string tag);
        bit old_nmi;
        @(negedge clk);
        wr_valid = wv; wr_enable = en; wr_key = 8'(key); wr_reload = rl;
        wr_count = 8'(cnt); tick = tk; ext_nmi = ext;
        old_nmi = (m_state == 2);
        m_pend  = {old_nmi, ext};
        m_rst   = 1'b0;
        if (wv && key == KEY) begin
            if (!en) m_state = 0;
            else begin
                if (m_state == 0 || rl) m_cnt = (cnt == 0) ? 256 : cnt;
                m_state = 1;
            end
        end else if (tk && m_state != 0) begin
            if (m_cnt <= 1) begin
                if (m_state == 1) begin m_state = 2; m_cnt = GRACE; end
                else begin m_state = 0; m_rst = 1'b1; end
            end else m_cnt = m_cnt - 1;
        end
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0, tag);
    endtask

    task automatic arm(int cnt, bit rl, string tag);
        step(1, 1, KEY, rl, cnt, 0, 0, tag);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R1");

        // R2: wrong key ignored
        step(1, 1, 8'h5A, 1, 3, 0, 0, "R2");
        ticks(6, "R2");

        // R3, R4, R5: arm with 3, warn, grace, bite
        arm(3, 1, "R3");
        ticks(2, "R3");
        ticks(1, "R4");
        ticks(GRACE - 1, "R4");
        ticks(1, "R5");
        ticks(3, "R5");

        // R3: count 0 means 256
        arm(0, 1, "R3");
        ticks(255, "R3");
        ticks(1, "R3");

        // R6: write clears NMI and history
        arm(4, 1, "R6");
        ticks(4, "R6");
        ticks(2, "R6");

        // R7: kick without reload keeps the grace remainder
        arm(50, 0, "R7");
        ticks(GRACE - 3, "R7");
        arm(50, 1, "R7");
        ticks(52, "R7");

        // R8: disarm stops counting
        arm(2, 1, "R8");
        step(1, 0, KEY, 0, 0, 0, 0, "R8");
        ticks(20, "R8");

        // R9: no-tick cycles and write-beats-tick
        arm(2, 1, "R9");
        repeat (10) step(0, 0, 0, 0, 0, 0, 0, "R9");
        ticks(1, "R9");
        step(1, 1, KEY, 0, 0, 1, 0, "R9");
        ticks(1, "R9");
        ticks(1, "R9");

        // R10: external source and merge
        step(0, 0, 0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit wv  = ($urandom % 30) == 0;
            bit en  = ($urandom % 6) != 0;
            int key = (($urandom % 5) == 0) ? int'($urandom % 256) : KEY;
            bit rl  = ($urandom % 3) != 0;
            int cnt = (($urandom % 40) == 0) ? 0 : int'($urandom % 24);
            bit tk  = ($urandom % 4) != 0;
            bit ext = ($urandom % 8) == 0;
            step(wv, en, key, rl, cnt, tk, ext, "R4/R5/R6 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule